// File: doc/BRIEF.md
# Periodic Descriptor Slot Scanner

This block manages a buffer of interrupt-transfer descriptors that is divided into equal, fixed-stride slots. Software configures the block through a command-coded register port. It sets the slot stride in bytes, writes a 32-bit mask of slots to pass over, and collects a 32-bit map of slots that completed with an acknowledge.

On each frame tick the block walks slots 0 to 31 in order. It derives each slot's byte address by adding the stride to a running total, and steps past masked slots at the cost of one address step. For every other slot it raises a process request and waits for a response carrying an acknowledge outcome. When the walk ends, it merges the frame's outcome bits into the completion map, and a software read clears that map. Descriptor contents, the buffer memory and bus signalling stay outside the block. A request/response pair stands in for the processing of a slot.

Top module: `pscan_ctrl`

## Requirements
- R1: After reset the stride reads 64, the skip mask and the completion map read 0, `scan_busy` is 0 and `overrun_cnt` is 0.
- R2: Command codes on `host_code` with `host_valid`: 53h reads the stride, D3h writes it, 18h reads the skip mask, 98h writes it, 17h reads the completion map. A read returns `host_rvalid`=1 with data on `host_rdata` one cycle after the command. Stride reads put the stride in bits 9:0 and zeros in bits 31:10. Any other code changes no state and produces no response.
- R3: A stride write takes `host_wdata[15:0]`. It is accepted only if that value is nonzero, a multiple of 8 and at most 1016, which is the largest multiple of 8 that fits the 10-bit field. Any other value leaves the stride unchanged and raises `cfg_err` for one cycle after the command.
- R4: A frame tick while idle starts a scan with the stride captured at that moment. `scan_busy` stays high until the results are posted. Requests go out in ascending slot order, and slot n has address n × stride.
- R5: When skip-mask bit n is 1, slot n gets no request.
- R6: `proc_req` stays high with stable `proc_slot` and `proc_addr` until the cycle in which `proc_ack` is sampled high. `proc_ok` is sampled in that same cycle.
- R7: The scan ends after slot 31, or at the first slot n whose end address (n+1) × stride would exceed BUF_BYTES, whichever comes first.
- R8: At the end of a scan, completion bit n is ORed in for each slot that got a request and was answered with `proc_ok`=1. Bit n refers to slot n.
- R9: A completion-map read returns the current map and then clears it to zero.
- R10: If results are posted in the same cycle as a completion-map read, the read returns the old map and the map afterwards holds only the new frame's bits.
- R11: A frame tick while `scan_busy` is high increments `overrun_cnt` and does not restart or extend the scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Command strobe |
| host_code | input | 8 | Command code |
| host_wdata | input | 32 | Write data |
| host_rvalid | output | 1 | Read data valid |
| host_rdata | output | 32 | Read data |
| cfg_err | output | 1 | Rejected stride write pulse |
| frame_tick | input | 1 | Start-of-frame pulse |
| scan_busy | output | 1 | Scan in progress |
| overrun_cnt | output | OVW | Count of ticks that arrived during a scan |
| proc_req | output | 1 | Slot process request |
| proc_slot | output | 5 | Slot index of the request |
| proc_addr | output | AW | Byte address of the slot |
| proc_ack | input | 1 | Process response strobe |
| proc_ok | input | 1 | Response outcome, 1 = acknowledged |

## Verification
The bench targets the stride limits 0, 12 and 1024, which a lax validator would store. It also targets a stride of 64 against a 1024-byte buffer: a walker with a wrong bound would issue a request for slot 16 or stop early. A result post timed to land on the same cycle as a map read would lose the new bits or keep the stale ones if the merge were ordered wrongly. Delayed acknowledges expose a request that drops or moves its address before the response. A tick during a scan exposes a walker that restarts and repeats slot 0 instead of counting an overrun.

// File: rtl/pscan_pkg.sv
package pscan_pkg;
    localparam logic [7:0] CODE_DONE_RD = 8'h17;
    localparam logic [7:0] CODE_SKIP_RD = 8'h18;
    localparam logic [7:0] CODE_SKIP_WR = 8'h98;
    localparam logic [7:0] CODE_SIZE_RD = 8'h53;
    localparam logic [7:0] CODE_SIZE_WR = 8'hD3;

    localparam int SLOTS    = 32;
    localparam int SLOT_IW  = $clog2(SLOTS);
    localparam int SIZE_W   = 10;
    localparam int SIZE_RST = 64;
    localparam int SIZE_MAX = 1016;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_REQ,
        ST_POST
    } scan_st_e;
endpackage

// File: rtl/pscan_regs.sv
module pscan_regs
    import pscan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    input  logic [7:0]        host_code,
    input  logic [31:0]       host_wdata,
    input  logic              post_valid,
    input  logic [SLOTS-1:0]  post_bits,
    output logic [SIZE_W-1:0] slot_size,
    output logic [SLOTS-1:0]  skip_map,
    output logic              host_rvalid,
    output logic [31:0]       host_rdata,
    output logic              cfg_err
);
    typedef struct packed {
        logic [SIZE_W-1:0] size;
        logic [SLOTS-1:0]  skip;
        logic [SLOTS-1:0]  done;
        logic              rvalid;
        logic [31:0]       rdata;
        logic              err;
    } regs_t;

    regs_t r_d, r_q;
    logic  rd_done;
    logic  size_ok;
    logic  unused_hi;

    assign unused_hi = &{1'b0, host_wdata[31:16]};

    always_comb begin
        r_d        = r_q;
        r_d.rvalid = 1'b0;
        r_d.err    = 1'b0;
        rd_done    = host_valid && (host_code == CODE_DONE_RD);
        size_ok    = (host_wdata[15:0] != 16'd0) && (host_wdata[2:0] == 3'd0)
                     && (host_wdata[15:0] <= 16'(SIZE_MAX));
        if (host_valid) begin
            case (host_code)
                CODE_DONE_RD: begin
                    r_d.rvalid = 1'b1;
                    r_d.rdata  = 32'(r_q.done);
                end
                CODE_SKIP_RD: begin
                    r_d.rvalid = 1'b1;
                    r_d.rdata  = 32'(r_q.skip);
                end
                CODE_SKIP_WR: r_d.skip = host_wdata[SLOTS-1:0];
                CODE_SIZE_RD: begin
                    r_d.rvalid = 1'b1;
                    r_d.rdata  = {{(32-SIZE_W){1'b0}}, r_q.size};
                end
                CODE_SIZE_WR: begin
                    if (size_ok) r_d.size = host_wdata[SIZE_W-1:0];
                    else         r_d.err  = 1'b1;
                end
                default: ;
            endcase
        end
        if (post_valid) begin
            r_d.done = rd_done ? post_bits : (r_q.done | post_bits);
        end else if (rd_done) begin
            r_d.done = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.size <= SIZE_W'(SIZE_RST);
        end else begin
            r_q <= r_d;
        end
    end

    assign slot_size   = r_q.size;
    assign skip_map    = r_q.skip;
    assign host_rvalid = r_q.rvalid;
    assign host_rdata  = r_q.rdata;
    assign cfg_err     = r_q.err;
endmodule

// File: rtl/pscan_walker.sv
module pscan_walker
    import pscan_pkg::*;
#(
    parameter int BUF_BYTES = 1024,
    parameter int AW        = 11,
    parameter int OVW       = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_tick,
    input  logic [SIZE_W-1:0]  slot_size,
    input  logic [SLOTS-1:0]   skip_map,
    input  logic               proc_ack,
    input  logic               proc_ok,
    output logic               scan_busy,
    output logic               proc_req,
    output logic [SLOT_IW-1:0] proc_slot,
    output logic [AW-1:0]      proc_addr,
    output logic               post_valid,
    output logic [SLOTS-1:0]   post_bits,
    output logic [OVW-1:0]     overrun_cnt
);
    localparam int IW = SLOT_IW + 1;
    localparam int EW = ((AW > SIZE_W) ? AW : SIZE_W) + 1;

    typedef struct packed {
        scan_st_e          st;
        logic [IW-1:0]     idx;
        logic [AW-1:0]     addr;
        logic [SIZE_W-1:0] size;
        logic [SLOTS-1:0]  bits;
        logic [OVW-1:0]    ovr;
    } walk_t;

    walk_t w_d, w_q;
    logic [EW-1:0] end_addr;
    logic          fits;
    logic          last_done;

    always_comb begin
        w_d       = w_q;
        end_addr  = EW'(w_q.addr) + EW'(w_q.size);
        fits      = end_addr <= EW'(BUF_BYTES);
        last_done = w_q.idx == IW'(SLOTS);
        if (frame_tick && (w_q.st != ST_IDLE)) w_d.ovr = w_q.ovr + 1'b1;
        case (w_q.st)
            ST_IDLE: if (frame_tick) begin
                w_d.st   = ST_CHECK;
                w_d.idx  = '0;
                w_d.addr = '0;
                w_d.size = slot_size;
                w_d.bits = '0;
            end
            ST_CHECK: begin
                if (last_done || !fits) begin
                    w_d.st = ST_POST;
                end else if (skip_map[w_q.idx[SLOT_IW-1:0]]) begin
                    w_d.idx  = w_q.idx + 1'b1;
                    w_d.addr = end_addr[AW-1:0];
                end else begin
                    w_d.st = ST_REQ;
                end
            end
            ST_REQ: if (proc_ack) begin
                w_d.bits[w_q.idx[SLOT_IW-1:0]] = proc_ok;
                w_d.idx  = w_q.idx + 1'b1;
                w_d.addr = end_addr[AW-1:0];
                w_d.st   = ST_CHECK;
            end
            default: w_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign scan_busy   = w_q.st != ST_IDLE;
    assign proc_req    = w_q.st == ST_REQ;
    assign proc_slot   = w_q.idx[SLOT_IW-1:0];
    assign proc_addr   = w_q.addr;
    assign post_valid  = w_q.st == ST_POST;
    assign post_bits   = w_q.bits;
    assign overrun_cnt = w_q.ovr;
endmodule

// File: rtl/pscan_ctrl.sv
module pscan_ctrl
    import pscan_pkg::*;
#(
    parameter int BUF_BYTES = 1024,
    parameter int OVW       = 8,
    localparam int AW       = $clog2(BUF_BYTES + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           host_valid,
    input  logic [7:0]     host_code,
    input  logic [31:0]    host_wdata,
    output logic           host_rvalid,
    output logic [31:0]    host_rdata,
    output logic           cfg_err,
    input  logic           frame_tick,
    output logic           scan_busy,
    output logic [OVW-1:0] overrun_cnt,
    output logic           proc_req,
    output logic [4:0]     proc_slot,
    output logic [AW-1:0]  proc_addr,
    input  logic           proc_ack,
    input  logic           proc_ok
);
    logic [SIZE_W-1:0] size_w;
    logic [SLOTS-1:0]  skip_w;
    logic              post_w;
    logic [SLOTS-1:0]  bits_w;

    pscan_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_valid (host_valid),
        .host_code  (host_code),
        .host_wdata (host_wdata),
        .post_valid (post_w),
        .post_bits  (bits_w),
        .slot_size  (size_w),
        .skip_map   (skip_w),
        .host_rvalid(host_rvalid),
        .host_rdata (host_rdata),
        .cfg_err    (cfg_err)
    );

    pscan_walker #(
        .BUF_BYTES(BUF_BYTES),
        .AW       (AW),
        .OVW      (OVW)
    ) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .slot_size  (size_w),
        .skip_map   (skip_w),
        .proc_ack   (proc_ack),
        .proc_ok    (proc_ok),
        .scan_busy  (scan_busy),
        .proc_req   (proc_req),
        .proc_slot  (proc_slot),
        .proc_addr  (proc_addr),
        .post_valid (post_w),
        .post_bits  (bits_w),
        .overrun_cnt(overrun_cnt)
    );
endmodule

// File: rtl/pscan_checker.sv
module pscan_checker #(
    parameter int BUF_BYTES = 1024,
    parameter int AW        = 11,
    parameter int OVW       = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           host_valid,
    input logic [7:0]     host_code,
    input logic           host_rvalid,
    input logic           cfg_err,
    input logic           frame_tick,
    input logic           scan_busy,
    input logic [OVW-1:0] overrun_cnt,
    input logic           proc_req,
    input logic [4:0]     proc_slot,
    input logic [AW-1:0]  proc_addr,
    input logic           proc_ack,
    input logic [9:0]     size_w
);
    AST_REQ_IN_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        proc_req |-> scan_busy); // R4
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        proc_req && !proc_ack |=> proc_req && $stable(proc_addr) && $stable(proc_slot)); // R6
    AST_REQ_IN_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        proc_req |-> (32'(proc_addr) + 32'd8 <= 32'(BUF_BYTES))); // R7
    AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (size_w != 10'd0) && (size_w[2:0] == 3'd0)); // R3
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> $past(host_valid && (host_code == 8'hD3))); // R3
    AST_RSP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> $past(host_valid)); // R2
    AST_OVR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick && scan_busy |=> overrun_cnt == $past(overrun_cnt) + 1'b1); // R11
endmodule

bind pscan_ctrl pscan_checker #(
    .BUF_BYTES(BUF_BYTES),
    .AW       (AW),
    .OVW      (OVW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_valid (host_valid),
    .host_code  (host_code),
    .host_rvalid(host_rvalid),
    .cfg_err    (cfg_err),
    .frame_tick (frame_tick),
    .scan_busy  (scan_busy),
    .overrun_cnt(overrun_cnt),
    .proc_req   (proc_req),
    .proc_slot  (proc_slot),
    .proc_addr  (proc_addr),
    .proc_ack   (proc_ack),
    .size_w     (size_w)
);

// File: tb/pscan_ctrl_bench.sv
module pscan_ctrl_bench;
    localparam int BUF = 1024;
    localparam int AWB = $clog2(BUF + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            host_valid = 1'b0;
    logic [7:0]      host_code = 8'h00;
    logic [31:0]     host_wdata = 32'h0;
    logic            host_rvalid;
    logic [31:0]     host_rdata;
    logic            cfg_err;
    logic            frame_tick = 1'b0;
    logic            scan_busy;
    logic [7:0]      overrun_cnt;
    logic            proc_req;
    logic [4:0]      proc_slot;
    logic [AWB-1:0]  proc_addr;
    logic            proc_ack = 1'b0;
    logic            proc_ok = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    int ack_delay = 0;
    logic [31:0] ok_pat = 32'hFFFF_FFFF;
    int m_size = 64;
    logic [31:0] m_skip = 32'h0;
    int q_slot[$];
    int q_addr[$];

    always #10 clk = ~clk;

    pscan_ctrl #(.BUF_BYTES(BUF), .OVW(8)) u_pscan_ctrl (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_code(host_code),
        .host_wdata(host_wdata), .host_rvalid(host_rvalid), .host_rdata(host_rdata),
        .cfg_err(cfg_err), .frame_tick(frame_tick), .scan_busy(scan_busy),
        .overrun_cnt(overrun_cnt), .proc_req(proc_req), .proc_slot(proc_slot),
        .proc_addr(proc_addr), .proc_ack(proc_ack), .proc_ok(proc_ok)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // responder: acknowledges a request after ack_delay idle cycles
    initial begin
        int waited = 0;
        forever begin
            @(negedge clk);
            if (proc_req && !proc_ack) begin
                if (waited < ack_delay) waited++;
                else begin
                    proc_ack = 1'b1;
                    proc_ok  = ok_pat[proc_slot];
                    waited   = 0;
                end
            end else begin
                proc_ack = 1'b0;
            end
        end
    end

    // reference model compared on every clock: request order, slot, address, hold
    initial begin
        logic last = 1'b0;
        int cur_a = 0;
        int cur_s = 0;
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && proc_req) begin
                if (!last) begin
                    if (q_slot.size() == 0) begin
                        chk("R5 unexpected request slot", 32'(proc_slot), 32'hFFFF_FFFF);
                    end else begin
                        cur_s = q_slot.pop_front();
                        cur_a = q_addr.pop_front();
                        chk("R4 request slot", 32'(proc_slot), 32'(cur_s));
                        chk("R4 request address", 32'(proc_addr), 32'(cur_a));
                    end
                end else begin
                    chk("R6 held address", 32'(proc_addr), 32'(cur_a));
                    chk("R6 held slot", 32'(proc_slot), 32'(cur_s));
                end
            end
            last = rst_n && proc_req;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    task automatic host_wr(input logic [7:0] c, input logic [31:0] w);
        host_valid = 1'b1; host_code = c; host_wdata = w;
        @(negedge clk);
        host_valid = 1'b0;
    endtask

    task automatic host_rd(input logic [7:0] c, output logic [31:0] d, output logic v);
        host_valid = 1'b1; host_code = c;
        @(negedge clk);
        host_valid = 1'b0;
        d = host_rdata; v = host_rvalid;
    endtask

    // expected completion bits of one scan, and its request list
    function automatic logic [31:0] plan_frame();
        logic [31:0] b = 32'h0;
        for (int n = 0; n < 32; n++) begin
            if ((n + 1) * m_size > BUF) break;
            if (!m_skip[n]) begin
                q_slot.push_back(n);
                q_addr.push_back(n * m_size);
                if (ok_pat[n]) b[n] = 1'b1;
            end
        end
        return b;
    endfunction

    task automatic tick();
        frame_tick = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0;
    endtask

    task automatic wait_idle();
        while (scan_busy) @(negedge clk);
        chk("R4 pending requests after scan", 32'(q_slot.size()), 32'd0);
    endtask

    initial begin
        logic [31:0] d;
        logic v;
        logic [31:0] eb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", 32'(scan_busy), 0);
        chk("R1 overrun", 32'(overrun_cnt), 0);
        host_rd(8'h53, d, v); chk("R1 stride", d, 64); chk("R2 stride rvalid", 32'(v), 1);
        host_rd(8'h18, d, v); chk("R1 skip", d, 0);
        host_rd(8'h17, d, v); chk("R1 done", d, 0);

        // R3 stride validation
        host_wr(8'hD3, 32'd32); chk("R3 good write err", 32'(cfg_err), 0);
        host_rd(8'h53, d, v); chk("R3 stride 32", d, 32);
        host_wr(8'hD3, 32'd0); chk("R3 zero rejected", 32'(cfg_err), 1);
        @(negedge clk); chk("R3 err one cycle", 32'(cfg_err), 0);
        host_wr(8'hD3, 32'd12); chk("R3 misaligned rejected", 32'(cfg_err), 1);
        host_wr(8'hD3, 32'd1024); chk("R3 1024 rejected", 32'(cfg_err), 1);
        host_rd(8'h53, d, v); chk("R3 stride kept", d, 32);
        host_wr(8'hD3, 32'd1016); host_rd(8'h53, d, v); chk("R3 stride 1016", d, 1016);
        chk("R2 stride upper bits zero", d & 32'hFFFF_FC00, 0);

        // R2 unknown code has no effect, no response
        host_wr(8'h42, 32'd16); chk("R2 unknown code rvalid", 32'(host_rvalid), 0);
        host_rd(8'h53, d, v); chk("R2 unknown code stride", d, 1016);

        // R2 skip register
        host_wr(8'h98, 32'hA5A5_0F0F); host_rd(8'h18, d, v); chk("R2 skip readback", d, 32'hA5A5_0F0F);

        // frame A: stride 64, 16 slots fit (R7), skips (R5), one nack (R8), slow acks (R6)
        m_size = 64; host_wr(8'hD3, 32'd64);
        m_skip = 32'h0000_0024; host_wr(8'h98, m_skip);
        ok_pat = 32'hFFFF_FF7F; ack_delay = 2;
        eb = plan_frame();
        tick(); chk("R4 busy after tick", 32'(scan_busy), 1);
        wait_idle();
        host_rd(8'h17, d, v); chk("R8 done frame A", d, eb); chk("R7 no slot past buffer", d & 32'hFFFF_0000, 0);
        host_rd(8'h17, d, v); chk("R9 cleared on read", d, 0);

        // frame B: stride 8, all slots fit, upper half processed, ends after slot 31 (R7)
        ack_delay = 0; ok_pat = 32'hFFFF_FFFF;
        m_size = 8; host_wr(8'hD3, 32'd8);
        m_skip = 32'h0000_FFFF; host_wr(8'h98, m_skip);
        eb = plan_frame(); tick(); wait_idle();
        chk("R7 slot 31 processed", eb, 32'hFFFF_0000);

        // frame C: results posted in the same cycle as a read (R10)
        m_skip = 32'hFFFF_FFFE; host_wr(8'h98, m_skip);
        eb = plan_frame(); tick();
        repeat (34) @(negedge clk);
        host_rd(8'h17, d, v); chk("R10 read returns old map", d, 32'hFFFF_0000);
        wait_idle();
        host_rd(8'h17, d, v); chk("R10 only new bits kept", d, eb);

        // frames D, E: results accumulate between reads (R8)
        m_skip = 32'hFFFF_FFFD; host_wr(8'h98, m_skip);
        eb = plan_frame(); tick(); wait_idle();
        m_skip = 32'hFFFF_FFFB; host_wr(8'h98, m_skip);
        eb = eb | plan_frame(); tick(); wait_idle();
        host_rd(8'h17, d, v); chk("R8 accumulated bits", d, 32'h0000_0006);

        // frame F: tick during scan counts an overrun, no restart (R11)
        m_size = 64; host_wr(8'hD3, 32'd64);
        m_skip = 32'h0; host_wr(8'h98, m_skip);
        ok_pat = 32'h0000_5A5A;
        eb = plan_frame(); tick();
        repeat (4) @(negedge clk);
        tick();
        @(negedge clk); chk("R11 overrun count", 32'(overrun_cnt), 1);
        wait_idle();
        chk("R11 still one overrun", 32'(overrun_cnt), 1);
        host_rd(8'h17, d, v); chk("R11 one scan posted", d, eb);
        repeat (5) @(negedge clk);
        chk("R11 no restart", 32'(scan_busy), 0);

        summary();
    end
endmodule